// File: doc/BRIEF.md
# DMA Master Read-Error Fatal Latch

This block sits between the DMA engines and the internal bus on the master side. It passes read requests from the engines to the bus and counts the reads still waiting for their push data. It also watches the returning push beats for a data-error flag. A flagged beat counts as a fatal fault:
- the block raises a sticky interrupt cause;
- it captures the failing read's tag and a fatal bit in a status register;
- it strobes an abort to the bus side and discards all outstanding reads;
- it closes the request gate.

The gate stays closed until software applies a soft reset. The soft reset reopens the gate and empties the outstanding count. It leaves the interrupt cause and the captured status in place, so the fault can still be inspected and acknowledged. The interrupt cause is cleared by a separate clear input.

Each returning push beat completes exactly one outstanding read. The count saturates at a parameterised ceiling, and while the count sits at that ceiling the gate refuses new requests.

Top module: `dma_fatal_latch`

## Requirements
- R1: After hard reset (`rst_n` low) all of the following read 0: `blocked_o`, `irq_cause`, `stat_fatal`, `stat_tag`, `abort_o` and `out_count`.
- R2: While `blocked_o` is 0 and `out_count` is below MAX_OUT, the gate is transparent in the same cycle:
  - `bus_req_valid` equals `req_valid_in`;
  - `bus_req_tag` equals `req_tag_in`;
  - `req_ready_out` equals `bus_req_ready`.
- R3: Updates to `out_count`:
  - It rises by one on each cycle with `bus_req_valid` and `bus_req_ready` both 1.
  - It falls by one on each cycle with `push_valid` 1 while it is nonzero. Both in one cycle leave it unchanged.
  - At MAX_OUT, `bus_req_valid` and `req_ready_out` are held at 0.
- R4: A beat with `push_valid`=1 and `push_err`=1, while `blocked_o` is 0 and `soft_rst` is 0, sets `irq_cause` to 1 on the next cycle.
- R5: The same fault event sets `stat_fatal` to 1 and loads `stat_tag` with `push_tag` on the next cycle.
- R6: The fault event makes `abort_o` high for exactly one cycle, namely the next cycle. In that cycle `out_count` is 0.
- R7: From the cycle after the fault event, `blocked_o` is 1. While it is 1, `bus_req_valid` and `req_ready_out` are 0 whatever the inputs are, and `out_count` does not rise.
- R8: Error beats that arrive while `blocked_o` is 1 leave `stat_tag` unchanged and produce no `abort_o` pulse.
- R9: A cycle with `soft_rst`=1 clears `blocked_o` and `out_count` on the next cycle. It leaves `irq_cause`, `stat_fatal` and `stat_tag` unchanged. An error beat in that same cycle is ignored.
- R10: `irq_clr`=1 clears `irq_cause` on the next cycle, unless a fault event occurs in the same cycle; in that case `irq_cause` stays 1.
- R11: A push beat with `push_err`=0 never raises a fault. A push beat while `out_count` is 0 leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| req_valid_in | input | 1 | Read request from DMA engines |
| req_tag_in | input | TAG_W | Tag of the request |
| req_ready_out | output | 1 | Request accepted toward engines |
| bus_req_valid | output | 1 | Read request toward the bus |
| bus_req_tag | output | TAG_W | Tag toward the bus |
| bus_req_ready | input | 1 | Bus accepts request |
| push_valid | input | 1 | Push data beat returns |
| push_err | input | 1 | Data-error flag on the beat |
| push_tag | input | TAG_W | Tag of the returning beat |
| abort_o | output | 1 | One-cycle abort of all outstanding reads |
| out_count | output | CNT_W | Outstanding read count |
| blocked_o | output | 1 | Request inhibit in force |
| irq_cause | output | 1 | Sticky internal-bus error cause |
| irq_clr | input | 1 | Software clear of the cause |
| stat_fatal | output | 1 | Status: fatal fault captured |
| stat_tag | output | TAG_W | Status: tag of the failing read |

## Verification
The hardest cases to reach are the same-cycle collisions:
- an error beat in the very cycle of a soft reset;
- an error beat in the same cycle as an interrupt clear;
- a full count of outstanding reads with no completions.

The stimulus first issues MAX_OUT back-to-back reads with no push beats, to pin the count at its ceiling. Later it drives an error beat together with `irq_clr`, and another together with `soft_rst`. It then checks that the captured tag comes from the first collision and not from the beat that arrived during the soft reset.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

  typedef enum logic {
    FLT_OPEN    = 1'b0,
    FLT_LATCHED = 1'b1
  } flt_state_e;

  // Next occupancy of the outstanding-read counter.
  function automatic int unsigned occ_next(int unsigned cur, logic inc, logic dec);
    int unsigned v;
    v = cur;
    if (inc) v = v + 1;
    if (dec && (cur != 0)) v = v - 1;
    return v;
  endfunction

endpackage

// File: rtl/dfl_gate.sv
module dfl_gate #(
  parameter int TAG_W = 6
) (
  input  logic             blocked,
  input  logic             full,
  input  logic             req_valid_in,
  input  logic [TAG_W-1:0] req_tag_in,
  input  logic             bus_req_ready,
  output logic             req_ready_out,
  output logic             bus_req_valid,
  output logic [TAG_W-1:0] bus_req_tag,
  output logic             issue
);
  logic open_w;

  assign open_w        = !blocked && !full;
  assign bus_req_valid = req_valid_in && open_w;
  assign req_ready_out = bus_req_ready && open_w;
  assign bus_req_tag   = req_tag_in;
  assign issue         = bus_req_valid && bus_req_ready;
endmodule

// File: rtl/dfl_outstanding.sv
module dfl_outstanding #(
  parameter int MAX_OUT = 16,
  parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue,
  input  logic             done_beat,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import dfl_pkg::*;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= CNT_W'(occ_next(32'(count_q), issue, done_beat));
  end

  assign count = count_q;
  assign full  = (count_q == CNT_W'(MAX_OUT));
endmodule

// File: rtl/dfl_fault_capture.sv
module dfl_fault_capture #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             push_valid,
  input  logic             push_err,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             irq_clr,
  output logic             err_evt,
  output logic             blocked,
  output logic             abort,
  output logic             irq_cause,
  output logic             stat_fatal,
  output logic [TAG_W-1:0] stat_tag
);
  import dfl_pkg::*;

  flt_state_e       state_q;
  logic             abort_q;
  logic             cause_q;
  logic             fatal_q;
  logic [TAG_W-1:0] tag_q;

  assign err_evt = push_valid && push_err && (state_q == FLT_OPEN) && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLT_OPEN;
      abort_q <= 1'b0;
    end else begin
      abort_q <= err_evt;
      if (soft_rst)     state_q <= FLT_OPEN;
      else if (err_evt) state_q <= FLT_LATCHED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause_q <= 1'b0;
    else if (err_evt) cause_q <= 1'b1;
    else if (irq_clr) cause_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
      tag_q   <= '0;
    end else if (err_evt) begin
      fatal_q <= 1'b1;
      tag_q   <= push_tag;
    end
  end

  assign blocked    = (state_q == FLT_LATCHED);
  assign abort      = abort_q;
  assign irq_cause  = cause_q;
  assign stat_fatal = fatal_q;
  assign stat_tag   = tag_q;
endmodule

// File: rtl/dma_fatal_latch.sv
module dma_fatal_latch #(
  parameter int TAG_W   = 6,
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             req_valid_in,
  input  logic [TAG_W-1:0] req_tag_in,
  output logic             req_ready_out,
  output logic             bus_req_valid,
  output logic [TAG_W-1:0] bus_req_tag,
  input  logic             bus_req_ready,
  input  logic             push_valid,
  input  logic             push_err,
  input  logic [TAG_W-1:0] push_tag,
  output logic             abort_o,
  output logic [CNT_W-1:0] out_count,
  output logic             blocked_o,
  output logic             irq_cause,
  input  logic             irq_clr,
  output logic             stat_fatal,
  output logic [TAG_W-1:0] stat_tag
);
  // Internal events, named for the checker.
  logic err_evt;
  logic issue;
  logic full;
  logic cnt_clr;

  assign cnt_clr = soft_rst || err_evt;

  dfl_fault_capture #(.TAG_W(TAG_W)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .push_valid (push_valid),
    .push_err   (push_err),
    .push_tag   (push_tag),
    .irq_clr    (irq_clr),
    .err_evt    (err_evt),
    .blocked    (blocked_o),
    .abort      (abort_o),
    .irq_cause  (irq_cause),
    .stat_fatal (stat_fatal),
    .stat_tag   (stat_tag)
  );

  dfl_gate #(.TAG_W(TAG_W)) u_gate (
    .blocked       (blocked_o),
    .full          (full),
    .req_valid_in  (req_valid_in),
    .req_tag_in    (req_tag_in),
    .bus_req_ready (bus_req_ready),
    .req_ready_out (req_ready_out),
    .bus_req_valid (bus_req_valid),
    .bus_req_tag   (bus_req_tag),
    .issue         (issue)
  );

  dfl_outstanding #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .issue     (issue),
    .done_beat (push_valid),
    .count     (out_count),
    .full      (full)
  );
endmodule

// File: rtl/dfl_checker.sv
module dfl_checker #(
  parameter int TAG_W   = 6,
  parameter int MAX_OUT = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             push_valid,
  input logic             push_err,
  input logic             err_evt,
  input logic             blocked_o,
  input logic             bus_req_valid,
  input logic             req_ready_out,
  input logic             abort_o,
  input logic             irq_cause,
  input logic [TAG_W-1:0] stat_tag,
  input logic [CNT_W-1:0] out_count
);
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |-> (!bus_req_valid && !req_ready_out)); // R7
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R6
  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (out_count == '0)); // R6
  AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_err && !blocked_o && !soft_rst) |=> (irq_cause && blocked_o)); // R4
  AST_EVT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !blocked_o); // R8
  AST_TAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |=> $stable(stat_tag)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(MAX_OUT)); // R3
  AST_SOFT_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!blocked_o && out_count == '0)); // R9
endmodule

bind dma_fatal_latch dfl_checker #(.TAG_W(TAG_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .push_valid    (push_valid),
  .push_err      (push_err),
  .err_evt       (err_evt),
  .blocked_o     (blocked_o),
  .bus_req_valid (bus_req_valid),
  .req_ready_out (req_ready_out),
  .abort_o       (abort_o),
  .irq_cause     (irq_cause),
  .stat_tag      (stat_tag),
  .out_count     (out_count)
);

// File: tb/sim_dma_fatal_latch.sv
`timescale 1ns/1ps
module sim_dma_fatal_latch;
  localparam int TAG_W   = 6;
  localparam int MAX_OUT = 16;
  localparam int CNT_W   = $clog2(MAX_OUT + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             soft_rst = 1'b0;
  logic             req_valid_in = 1'b0;
  logic [TAG_W-1:0] req_tag_in = '0;
  logic             req_ready_out;
  logic             bus_req_valid;
  logic [TAG_W-1:0] bus_req_tag;
  logic             bus_req_ready = 1'b0;
  logic             push_valid = 1'b0;
  logic             push_err = 1'b0;
  logic [TAG_W-1:0] push_tag = '0;
  logic             abort_o;
  logic [CNT_W-1:0] out_count;
  logic             blocked_o;
  logic             irq_cause;
  logic             irq_clr = 1'b0;
  logic             stat_fatal;
  logic [TAG_W-1:0] stat_tag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_fatal_latch #(.TAG_W(TAG_W), .MAX_OUT(MAX_OUT)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid_in(req_valid_in), .req_tag_in(req_tag_in), .req_ready_out(req_ready_out),
    .bus_req_valid(bus_req_valid), .bus_req_tag(bus_req_tag), .bus_req_ready(bus_req_ready),
    .push_valid(push_valid), .push_err(push_err), .push_tag(push_tag),
    .abort_o(abort_o), .out_count(out_count), .blocked_o(blocked_o),
    .irq_cause(irq_cause), .irq_clr(irq_clr), .stat_fatal(stat_fatal), .stat_tag(stat_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one clock; inputs change and outputs are sampled 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 blocked", int'(blocked_o), 0);
    chk("R1 irq_cause", int'(irq_cause), 0);
    chk("R1 stat_fatal", int'(stat_fatal), 0);
    chk("R1 stat_tag", int'(stat_tag), 0);
    chk("R1 abort", int'(abort_o), 0);
    chk("R1 count", int'(out_count), 0);
  endtask

  task automatic t_pass();
    req_valid_in = 1'b1; req_tag_in = 6'd5; bus_req_ready = 1'b0;
    #1;
    chk("R2 bus_valid", int'(bus_req_valid), 1);
    chk("R2 bus_tag", int'(bus_req_tag), 5);
    chk("R2 ready low", int'(req_ready_out), 0);
    bus_req_ready = 1'b1;
    #1;
    chk("R2 ready high", int'(req_ready_out), 1);
    tick();
    req_valid_in = 1'b0;
    chk("R3 count after one", int'(out_count), 1);
  endtask

  task automatic t_count();
    req_valid_in = 1'b1;
    tick(); tick();
    chk("R3 count three", int'(out_count), 3);
    push_valid = 1'b1;
    tick();
    chk("R3 issue plus done", int'(out_count), 3);
    req_valid_in = 1'b0;
    repeat (3) tick();
    chk("R3 drained", int'(out_count), 0);
    tick();
    chk("R11 no underflow", int'(out_count), 0);
    chk("R11 clean beats no cause", int'(irq_cause), 0);
    chk("R11 clean beats no block", int'(blocked_o), 0);
    push_valid = 1'b0;
  endtask

  task automatic t_saturate();
    req_valid_in = 1'b1; bus_req_ready = 1'b1;
    for (int i = 0; i < MAX_OUT; i++) tick();
    chk("R3 at ceiling", int'(out_count), MAX_OUT);
    chk("R3 full ready low", int'(req_ready_out), 0);
    chk("R3 full valid low", int'(bus_req_valid), 0);
    tick();
    chk("R3 holds ceiling", int'(out_count), MAX_OUT);
    req_valid_in = 1'b0; push_valid = 1'b1;
    for (int i = 0; i < MAX_OUT; i++) tick();
    push_valid = 1'b0;
    chk("R3 drained from ceiling", int'(out_count), 0);
  endtask

  task automatic t_error();
    req_valid_in = 1'b1; bus_req_ready = 1'b1;
    tick(); tick();
    chk("R3 before fault", int'(out_count), 2);
    push_valid = 1'b1; push_err = 1'b1; push_tag = 6'h2A;
    #1;
    chk("R7 gate open in fault cycle", int'(req_ready_out), 1);
    tick();
    push_valid = 1'b0; push_err = 1'b0;
    chk("R4 cause set", int'(irq_cause), 1);
    chk("R5 fatal bit", int'(stat_fatal), 1);
    chk("R5 tag captured", int'(stat_tag), 'h2A);
    chk("R6 abort pulse", int'(abort_o), 1);
    chk("R6 count zero", int'(out_count), 0);
    chk("R7 blocked", int'(blocked_o), 1);
    chk("R7 ready low", int'(req_ready_out), 0);
    chk("R7 valid low", int'(bus_req_valid), 0);
    tick();
    chk("R6 abort single", int'(abort_o), 0);
    chk("R7 count stays zero", int'(out_count), 0);
    chk("R7 still blocked", int'(blocked_o), 1);
    req_valid_in = 1'b0;
  endtask

  task automatic t_err_blocked();
    push_valid = 1'b1; push_err = 1'b1; push_tag = 6'h11;
    tick();
    push_valid = 1'b0; push_err = 1'b0;
    chk("R8 tag kept", int'(stat_tag), 'h2A);
    chk("R8 no abort", int'(abort_o), 0);
  endtask

  task automatic t_soft();
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk("R9 unblocked", int'(blocked_o), 0);
    chk("R9 count zero", int'(out_count), 0);
    chk("R9 cause kept", int'(irq_cause), 1);
    chk("R9 fatal kept", int'(stat_fatal), 1);
    chk("R9 tag kept", int'(stat_tag), 'h2A);
  endtask

  task automatic t_clr_collide();
    irq_clr = 1'b1; push_valid = 1'b1; push_err = 1'b1; push_tag = 6'h07;
    tick();
    irq_clr = 1'b0; push_valid = 1'b0; push_err = 1'b0;
    chk("R10 error beats clear", int'(irq_cause), 1);
    chk("R5 new tag after soft", int'(stat_tag), 7);
    chk("R7 blocked again", int'(blocked_o), 1);
  endtask

  task automatic t_soft_collide();
    soft_rst = 1'b1; push_valid = 1'b1; push_err = 1'b1; push_tag = 6'h33;
    tick();
    soft_rst = 1'b0; push_valid = 1'b0; push_err = 1'b0;
    chk("R9 error in soft cycle ignored", int'(blocked_o), 0);
    chk("R9 tag from earlier fault", int'(stat_tag), 7);
    chk("R9 no abort", int'(abort_o), 0);
    req_valid_in = 1'b1;
    repeat (3) tick();
    req_valid_in = 1'b0;
    chk("R3 count after reopen", int'(out_count), 3);
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk("R9 soft clears live count", int'(out_count), 0);
  endtask

  task automatic t_clr();
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    chk("R10 cause cleared", int'(irq_cause), 0);
    chk("R10 status kept", int'(stat_fatal), 1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_count();
    t_saturate();
    t_error();
    t_err_blocked();
    t_soft();
    t_clr_collide();
    t_soft_collide();
    t_clr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule